// File: doc/BRIEF.md
# Key-Guarded Two-Stage Watchdog

This block is a watchdog timer programmed through a single 32-bit control word. The control word carries an 8-bit reload count, a run command bit and a 7-bit key. A write loads the down-counter. While the run command is set, the counter steps down once for every cycle in which the slow tick-enable input is high. The nominal tick rate is 760 Hz, and a separate divider that is not part of this block produces it.

After the run command has been stored, software cannot rewrite the control word with an arbitrary value. A new write is taken only when its key field is the bitwise inverse of the key currently held. Any other write leaves the block exactly as it was.

Expiry escalates in two stages. The first time the count runs out, the block raises a non-maskable interrupt and reloads a short grace count. If software does not service the watchdog before the grace count also runs out, the block raises a system-reset request. That request stays high until the block itself is reset. A write that is taken clears the interrupt and the expiry history.

Top module: `guarded_watchdog`

## Requirements
- R1: After reset, `nmi_o` and `sysrst_req_o` are 0, the counter is stopped, and the stored control value is zero. The first write is therefore taken whatever its key.
- R2: The fields of a write are fixed. Bits [7:0] are the reload count, bit 8 is the run command, and bits [15:9] are the key. Bits [31:16] have no effect.
- R3: While the stored run bit is 1, a write is taken only if its key equals the bitwise inverse of the stored key. A write with any other key changes nothing. The countdown, `nmi_o` and the stored key are all left as they were.
- R4: A write that is taken with run command 1 and count N (1..255) makes `nmi_o` rise right after the N-th tick that follows. A count of 0 stands for 256 ticks.
- R5: A write that is taken with run command 0 stops the watchdog. No number of ticks then produces an expiry.
- R6: On the first expiry `nmi_o` goes to 1 and a grace count of GRACE_TICKS ticks (default 1) starts. When the grace count also runs out, `sysrst_req_o` goes to 1.
- R7: A write that is taken clears `nmi_o` on the next cycle and clears the expiry history. The next expiry is treated as a first expiry again.
- R8: Once `sysrst_req_o` is 1, it stays 1 until reset, even across writes that are taken. Counting stops.
- R9: The counter only moves in cycles where `tick_i` is 1. Idle cycles change nothing.
- R10: When a write that is taken and a tick fall in the same cycle, the write wins and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable pulse of the slow countdown tick |
| wr_i | input | 1 | Control write strobe |
| wdata_i | input | 32 | Control write value |
| nmi_o | output | 1 | Non-maskable interrupt, first-stage expiry |
| sysrst_req_o | output | 1 | Sticky system-reset request, second-stage expiry |

## Verification
Every reload count from 1 to 256 is swept, with the key chain continued correctly on each write. This shows the exact tick on which the interrupt appears and proves that zero is decoded as 256. Writes with a near-miss key are issued while the watchdog is running and while the interrupt is up. Any effect they had would shift or clear the expected expiry, so the original expiry schedule must survive them. Separate patterns cover a stop command, long idle gaps between ticks, a write that coincides with a tick, and a full escalation to the reset request followed by writes. Together these tell apart the write/tick priority, the history clear and the stickiness of the reset request.

// File: rtl/gwd_pkg.sv
package gwd_pkg;

   // Escalation stage of the watchdog.
   typedef enum logic [1:0] {
      STG_IDLE    = 2'd0,   // stopped, no pending expiry
      STG_ARMED   = 2'd1,   // counting toward the first expiry
      STG_GRACE   = 2'd2,   // interrupt raised, grace count running
      STG_TRIPPED = 2'd3    // reset requested, frozen until reset
   } gwd_stage_e;

   // Decoded fields of one control write.
   typedef struct packed {
      logic [6:0] key;
      logic       run;
      logic [7:0] count;
   } gwd_fields_t;

   // Expand a raw count field: zero means the full range.
   function automatic logic [8:0] gwd_expand_count(input logic [7:0] c);
      return (c == 8'd0) ? 9'd256 : {1'b0, c};
   endfunction

endpackage

// File: rtl/gwd_ctrl_gate.sv
module gwd_ctrl_gate #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned KEY_W     = 7,
   parameter bit          KEY_GUARD = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic                accept_o,
   output logic [CNT_W-1:0]    count_o,
   output logic                run_o
);
   localparam int unsigned RUN_POS = CNT_W;
   localparam int unsigned KEY_LO  = CNT_W + 1;
   localparam int unsigned FIELD_W = CNT_W + 1 + KEY_W;

   if (FIELD_W > DATA_W) begin : g_chk_width
      $error("control fields do not fit the data word");
   end

   logic [KEY_W-1:0] key_q;
   logic             run_q;
   logic [KEY_W-1:0] new_key;
   logic             key_match;

   assign new_key = wdata_i[KEY_LO +: KEY_W];
   assign count_o = wdata_i[CNT_W-1:0];
   assign run_o   = wdata_i[RUN_POS];

   if (DATA_W > FIELD_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:FIELD_W];
   end

   if (KEY_GUARD) begin : g_guard
      assign key_match = (new_key == ~key_q);
      assign accept_o  = wr_i && (!run_q || key_match);
   end else begin : g_open
      assign key_match = 1'b1;
      assign accept_o  = wr_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_q <= '0;
         run_q <= 1'b0;
      end else if (accept_o) begin
         key_q <= new_key;
         run_q <= wdata_i[RUN_POS];
      end
   end

   // A refused write must leave the stored key and run bit untouched (R3)
   p_refused_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !accept_o) |=> ($stable(key_q) && $stable(run_q)));

endmodule

// File: rtl/gwd_down_counter.sv
module gwd_down_counter #(
   parameter int unsigned W = 9
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         step_i,
   output logic         expire_o
);
   logic [W-1:0] cnt_q;

   assign expire_o = step_i && (cnt_q == W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (step_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   // Without a step or a load the count stays put (R9)
   p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/gwd_escalate.sv
module gwd_escalate
   import gwd_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic accept_i,
   input  logic run_cmd_i,
   input  logic expire_i,
   output logic counting_o,
   output logic grace_load_o,
   output logic nmi_o,
   output logic trip_o
);
   gwd_stage_e stage_q;
   logic       nmi_q;

   assign counting_o   = (stage_q == STG_ARMED) || (stage_q == STG_GRACE);
   assign grace_load_o = expire_i && (stage_q == STG_ARMED);
   assign nmi_o        = nmi_q;
   assign trip_o       = (stage_q == STG_TRIPPED);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q <= STG_IDLE;
         nmi_q   <= 1'b0;
      end else if (accept_i) begin
         nmi_q <= 1'b0;
         if (stage_q != STG_TRIPPED) begin
            stage_q <= run_cmd_i ? STG_ARMED : STG_IDLE;
         end
      end else if (expire_i) begin
         unique case (stage_q)
            STG_ARMED: begin
               stage_q <= STG_GRACE;
               nmi_q   <= 1'b1;
            end
            STG_GRACE: stage_q <= STG_TRIPPED;
            default:   stage_q <= stage_q;
         endcase
      end
   end

   // Reset request is sticky (R8)
   p_trip_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_o |=> trip_o);

   // Interrupt always comes before the reset request (R6)
   p_trip_after_nmi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(trip_o) |-> nmi_q);

   // Accepted write drops the interrupt (R7)
   p_accept_clears_nmi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_i |=> !nmi_q);

endmodule

// File: rtl/guarded_watchdog.sv
module guarded_watchdog
   import gwd_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned GRACE_TICKS = 1,
   parameter bit          KEY_GUARD   = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        tick_i,
   input  logic        wr_i,
   input  logic [31:0] wdata_i,
   output logic        nmi_o,
   output logic        sysrst_req_o
);
   localparam int unsigned CNT_W = $bits(gwd_fields_t) - 8;
   localparam int unsigned KEY_W = 7;
   localparam int unsigned CW    = CNT_W + 1;

   if (GRACE_TICKS < 1 || GRACE_TICKS > (1 << CNT_W)) begin : g_chk_grace
      $error("GRACE_TICKS out of range");
   end
   if (DATA_W != 32) begin : g_chk_data
      $error("DATA_W must match the 32-bit port");
   end

   logic             accept;
   logic [CNT_W-1:0] wr_count;
   logic             wr_run;
   logic             counting;
   logic             grace_load;
   logic             expire;
   logic             step;
   logic             load;
   logic [CW-1:0]    load_val;

   gwd_ctrl_gate #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .KEY_W     (KEY_W),
      .KEY_GUARD (KEY_GUARD)
   ) i_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_i),
      .wdata_i  (wdata_i),
      .accept_o (accept),
      .count_o  (wr_count),
      .run_o    (wr_run)
   );

   // A write in the same cycle as a tick wins; the tick is dropped.
   assign step     = tick_i && counting && !accept;
   assign load     = accept || grace_load;
   assign load_val = accept ? gwd_expand_count(wr_count) : CW'(GRACE_TICKS);

   gwd_down_counter #(
      .W (CW)
   ) i_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (load_val),
      .step_i     (step),
      .expire_o   (expire)
   );

   gwd_escalate i_esc (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .accept_i     (accept),
      .run_cmd_i    (wr_run),
      .expire_i     (expire),
      .counting_o   (counting),
      .grace_load_o (grace_load),
      .nmi_o        (nmi_o),
      .trip_o       (sysrst_req_o)
   );

   // No expiry can happen while the watchdog is stopped (R5)
   p_no_expire_stopped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !counting |-> !expire);

endmodule

// File: tb/test_guarded_watchdog.sv
module test_guarded_watchdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        nmi;
   logic        srq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [6:0] key_s = '0;
   logic       run_s = 1'b0;

   always #10 clk = ~clk;

   guarded_watchdog i_guarded_watchdog (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr),
      .wdata_i(wdata), .nmi_o(nmi), .sysrst_req_o(srq)
   );

   task automatic chk(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; wr = 1'b0; tick = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; key_s = '0; run_s = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr_raw(input logic [31:0] d);
      @(negedge clk); wr = 1'b1; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   // Write that the bench expects to be taken; upper bits carry junk (R2).
   task automatic wr_ok(input logic [7:0] cnt, input logic cmd, input logic [15:0] junk);
      logic [6:0] k;
      k = run_s ? ~key_s : (cnt[6:0] ^ 7'h2A);
      wr_raw({junk, k, cmd, cnt});
      key_s = k; run_s = cmd;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk(nmi, 1'b0, "R1 nmi after reset");
      chk(srq, 1'b0, "R1 reset request after reset");
      ticks(300);
      chk(nmi, 1'b0, "R1 stopped after reset");

      // Full escalation, then stickiness
      wr_ok(8'd4, 1'b1, 16'hDEAD);
      ticks(3); chk(nmi, 1'b0, "R4 before expiry");
      ticks(1); chk(nmi, 1'b1, "R6 first expiry nmi");
      chk(srq, 1'b0, "R6 no reset at first expiry");
      ticks(1); chk(srq, 1'b1, "R6 grace expiry reset request");
      ticks(3); chk(srq, 1'b1, "R8 sticky under ticks");
      wr_ok(8'd5, 1'b1, 16'h0000);
      chk(srq, 1'b1, "R8 sticky across write");
      chk(nmi, 1'b0, "R7 write clears nmi");
      ticks(10); chk(nmi, 1'b0, "R8 counting stopped after trip");
      do_reset();
      chk(srq, 1'b0, "R8 cleared by reset");

      // Sweep every reload count; junk in upper bits (R2), 0 means 256 (R4)
      for (int n = 1; n <= 256; n++) begin
         wr_ok(8'(n), 1'b1, 16'(n * 16'h9E37));
         chk(nmi, 1'b0, "R7 nmi cleared by write in sweep");
         ticks(n - 1); chk(nmi, 1'b0, "R4 sweep before expiry");
         ticks(1);     chk(nmi, 1'b1, "R4 sweep expiry tick (R2 fields)");
      end

      // Stop command
      wr_ok(8'd2, 1'b0, 16'h1234);
      ticks(6); chk(nmi, 1'b0, "R5 stopped watchdog never expires");

      // Wrong key while running
      wr_ok(8'd6, 1'b1, 16'h0);
      ticks(2);
      wr_raw({16'h0, ~key_s ^ 7'h01, 1'b0, 8'd50});
      ticks(3); chk(nmi, 1'b0, "R3 refused write before expiry");
      ticks(1); chk(nmi, 1'b1, "R3 refused write kept schedule");
      wr_raw({16'h0, key_s, 1'b1, 8'd9});
      chk(nmi, 1'b1, "R3 refused write keeps nmi");
      wr_ok(8'd2, 1'b1, 16'h0);
      chk(nmi, 1'b0, "R3 correct key accepted");

      // Idle gaps between ticks
      wr_ok(8'd3, 1'b1, 16'h0);
      repeat (40) @(negedge clk);
      ticks(2); chk(nmi, 1'b0, "R9 idle cycles do not count");
      ticks(1); chk(nmi, 1'b1, "R9 expiry after three ticks");

      // Write and tick in the same cycle
      wr_ok(8'd1, 1'b1, 16'h0);
      @(negedge clk);
      wr = 1'b1; tick = 1'b1;
      wdata = {16'h0, ~key_s, 1'b1, 8'd2};
      key_s = ~key_s;
      @(negedge clk); wr = 1'b0; tick = 1'b0;
      chk(nmi, 1'b0, "R10 tick dropped on write cycle");
      ticks(1); chk(nmi, 1'b0, "R10 new count used");
      ticks(1); chk(nmi, 1'b1, "R10 expiry on new count");

      // History cleared by write
      wr_ok(8'd2, 1'b1, 16'h0);
      ticks(2); chk(nmi, 1'b1, "R7 first expiry");
      wr_ok(8'd2, 1'b1, 16'h0);
      ticks(2); chk(nmi, 1'b1, "R7 expiry treated as first again");
      chk(srq, 1'b0, "R7 no reset after history clear");
      ticks(1); chk(srq, 1'b1, "R6 grace then reset request");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule